// File: doc/BRIEF.md
# Power-Down Clock Output Sequencer

This block sits between the clock sources of a multi-output clock generator and its output pins. It watches an active-low power-down request. It accepts the request only after the request has been seen low on consecutive rising edges of the CPU complement clock. Once the request is accepted, the block parks every output domain low. Each domain parks at a clean point in its own waveform, so no domain ever emits a shortened pulse.

For the CPU differential pair, the block gives two controls. One holds the true output driven high. The other turns off the output enable of the complement output, so that output is left undriven. When the request returns high, the CPU pair is released at once, and each domain gate reopens on its own falling edge. A status output reports when every domain is parked.

The block treats each domain clock as asynchronous. The accepted request crosses into each domain through a synchronizer, and each parked flag crosses back into the CPU complement domain. The same sequence applies whatever the CPU frequency is.

Top module: `pdclk_park_seq`

## Requirements
- R1: A power-down is accepted only when `pwrdn_n` is sampled low on CONFIRM_EDGES (default 2) consecutive rising edges of `cpu_c_clk`. A single low sample is not enough, and neither is a low-high-low pattern.
- R2: From the rising edge that accepts the request, `cpu_t_hold_high` is 1 and `cpu_c_oe` is 0. Otherwise `cpu_t_hold_high` is 0 and `cpu_c_oe` is 1.
- R3: The first rising edge of `cpu_c_clk` that samples `pwrdn_n` high cancels the acceptance. After that edge, `cpu_t_hold_high` is 0 and `cpu_c_oe` is 1.
- R4: Each `dom_out[i]` is `dom_clk[i]` gated by an enable that changes only on a falling edge of `dom_clk[i]`. Every high pulse on `dom_out[i]` therefore lasts exactly one high phase of `dom_clk[i]`.
- R5: After acceptance, each `dom_out[i]` goes low within SYNC_STAGES+2 cycles of its own clock and stays low until release. A slow domain such as the reference clock may take several of its own cycles to do so.
- R6: After release, each domain resumes toggling within SYNC_STAGES+2 cycles of its own clock. Its first pulse is full width.
- R7: `all_parked` goes to 1 after every domain has parked, and returns to 0 after release once the domains run again.
- R8: While `rst_n` is low, all `dom_out` bits are 0, `cpu_t_hold_high` is 0, `cpu_c_oe` is 1 and `all_parked` is 0.
- R9: The accept, park and release behaviour is the same at every CPU complement clock frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_c_clk | input | 1 | CPU complement clock, samples the request |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Active-low power-down request |
| dom_clk | input | NUM_DOM | Free-running clock of each output domain |
| dom_out | output | NUM_DOM | Gated clock of each output domain |
| cpu_t_hold_high | output | 1 | Holds the true CPU output driven high |
| cpu_c_oe | output | 1 | Output enable of the complement CPU output |
| all_parked | output | 1 | All domains are parked low |

## Verification
The bench builds the block with its defaults: six domains, a two-edge accept and two-flop synchronizers. These defaults make the exact accept edge and the worst-case park latency predictable.

Each of the six domain clocks runs at its own half period. The slowest domain stands in for the reference clock, so its multi-cycle stop is exercised. The mix of periods also means the gates close and reopen at unrelated phases against the CPU clock. Every gated high pulse is timed against its domain's half period.

The whole park and release sequence is run a second time at a faster CPU complement clock.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [1:0] {
    QUAL_IDLE  = 2'd0,
    QUAL_COUNT = 2'd1,
    QUAL_PARK  = 2'd2
  } qual_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/pdseq_rst_sync.sv
module pdseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;
  logic [N-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[N-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[N-1];
endmodule

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] stg_q;
  logic [N-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[N-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {N{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[N-1];
endmodule

// File: rtl/pdseq_qualify.sv
module pdseq_qualify
  import pdseq_pkg::*;
#(
  parameter int unsigned CONFIRM_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic confirmed
);
  localparam int unsigned CW = cnt_width(CONFIRM_EDGES);
  localparam logic [CW-1:0] LIMIT = CW'(CONFIRM_EDGES);

  qual_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (req_n) begin
      state_d = QUAL_IDLE;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (state_q != QUAL_PARK) begin
      cnt_d   = cnt_q + 1'b1;
      cnt_en  = 1'b1;
      state_d = (cnt_d == LIMIT) ? QUAL_PARK : QUAL_COUNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= QUAL_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign confirmed = (state_q == QUAL_PARK);
endmodule

// File: rtl/pdseq_gate.sv
module pdseq_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic park_req,
  output logic gclk,
  output logic parked
);
  logic srst_n;
  logic park_s;
  logic en_q, en_d;

  pdseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (srst_n)
  );

  pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req (
    .clk   (clk),
    .rst_n (srst_n),
    .d     (park_req),
    .q     (park_s)
  );

  always_comb begin
    en_d = ~park_s;
  end

  // enable moves only while the clock is low
  always_ff @(negedge clk or negedge srst_n) begin
    if (!srst_n) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign gclk   = clk & en_q;
  assign parked = ~en_q;
endmodule

// File: rtl/pdclk_park_seq.sv
module pdclk_park_seq #(
  parameter int unsigned NUM_DOM       = 6,
  parameter int unsigned CONFIRM_EDGES = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic               cpu_c_clk,
  input  logic               rst_n,
  input  logic               pwrdn_n,
  input  logic [NUM_DOM-1:0] dom_clk,
  output logic [NUM_DOM-1:0] dom_out,
  output logic               cpu_t_hold_high,
  output logic               cpu_c_oe,
  output logic               all_parked
);
  logic               cpu_srst_n;
  logic               confirmed;
  logic [NUM_DOM-1:0] parked_raw;
  logic [NUM_DOM-1:0] parked_s;
  logic               all_parked_q, all_parked_d;

  pdseq_rst_sync #(.STAGES(SYNC_STAGES)) u_cpu_rst (
    .clk    (cpu_c_clk),
    .arst_n (rst_n),
    .srst_n (cpu_srst_n)
  );

  pdseq_qualify #(.CONFIRM_EDGES(CONFIRM_EDGES)) u_qual (
    .clk       (cpu_c_clk),
    .rst_n     (cpu_srst_n),
    .req_n     (pwrdn_n),
    .confirmed (confirmed)
  );

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    pdseq_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk      (dom_clk[g]),
      .arst_n   (rst_n),
      .park_req (confirmed),
      .gclk     (dom_out[g]),
      .parked   (parked_raw[g])
    );

    pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_back (
      .clk   (cpu_c_clk),
      .rst_n (cpu_srst_n),
      .d     (parked_raw[g]),
      .q     (parked_s[g])
    );
  end

  always_comb begin
    all_parked_d = &parked_s;
  end

  always_ff @(posedge cpu_c_clk or negedge cpu_srst_n) begin
    if (!cpu_srst_n) all_parked_q <= 1'b0;
    else             all_parked_q <= all_parked_d;
  end

  assign cpu_t_hold_high = confirmed;
  assign cpu_c_oe        = ~confirmed;
  assign all_parked      = all_parked_q;
endmodule

// File: rtl/pdclk_park_seq_chk.sv
module pdclk_park_seq_chk #(
  parameter int unsigned NUM_DOM = 6
) (
  input logic               cpu_c_clk,
  input logic               rst_n,
  input logic               pwrdn_n,
  input logic [NUM_DOM-1:0] dom_clk,
  input logic [NUM_DOM-1:0] dom_out,
  input logic               cpu_t_hold_high
);
  AST_ACCEPT_TWO_LOW: assert property (@(posedge cpu_c_clk) disable iff (!rst_n)
    $rose(cpu_t_hold_high) |-> (!pwrdn_n && !$past(pwrdn_n))); // R1

  AST_RELEASE_NEXT_EDGE: assert property (@(posedge cpu_c_clk) disable iff (!rst_n)
    pwrdn_n |=> !cpu_t_hold_high); // R3

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_chk
    always @(posedge dom_out[g]) begin
      if (rst_n) begin
        AST_GATE_RISE_ALIGNED: assert (dom_clk[g]); // R4
      end
    end
    always @(negedge dom_out[g]) begin
      if (rst_n) begin
        AST_GATE_FALL_ALIGNED: assert (!dom_clk[g]); // R4
      end
    end
  end
endmodule

bind pdclk_park_seq pdclk_park_seq_chk #(.NUM_DOM(NUM_DOM)) u_chk (
  .cpu_c_clk       (cpu_c_clk),
  .rst_n           (rst_n),
  .pwrdn_n         (pwrdn_n),
  .dom_clk         (dom_clk),
  .dom_out         (dom_out),
  .cpu_t_hold_high (cpu_t_hold_high)
);

// File: tb/test_pdclk_park_seq.sv
`timescale 1ns/1ps
module test_pdclk_park_seq;
  localparam int ND = 6;
  localparam int HALF [ND] = '{15, 35, 10, 4, 6, 8};

  logic          cpu_c_clk = 1'b0;
  logic          rst_n     = 1'b0;
  logic          pwrdn_n   = 1'b1;
  logic [ND-1:0] dom_clk;
  logic [ND-1:0] dom_out;
  logic          cpu_t_hold_high, cpu_c_oe, all_parked;

  int cpu_half = 10;
  int n_chk = 0;
  int n_fail = 0;
  int viol = 0;
  int pulses [ND];
  longint t_rise [ND];
  logic [ND-1:0] prev_out = '0;

  always #(cpu_half) cpu_c_clk = ~cpu_c_clk;

  for (genvar g = 0; g < ND; g++) begin : g_clk
    logic c = 1'b0;
    always #(HALF[g]) c = ~c;
    assign dom_clk[g] = c;
  end

  pdclk_park_seq i_pdclk_park_seq (
    .cpu_c_clk(cpu_c_clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
    .dom_clk(dom_clk), .dom_out(dom_out),
    .cpu_t_hold_high(cpu_t_hold_high), .cpu_c_oe(cpu_c_oe),
    .all_parked(all_parked)
  );

  initial begin
    for (int k = 0; k < ND; k++) begin pulses[k] = 0; t_rise[k] = -1; end
  end

  // pulse width monitor (R4, R6)
  always @(dom_out) begin
    for (int k = 0; k < ND; k++) begin
      if (dom_out[k] && !prev_out[k]) t_rise[k] = $time;
      if (!dom_out[k] && prev_out[k] && rst_n && t_rise[k] >= 0) begin
        pulses[k]++;
        if ($time - t_rise[k] != HALF[k]) viol++;
      end
    end
    prev_out = dom_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic t_reset();
    #50;
    chk(dom_out == '0, "R8 outputs", int'(dom_out), 0);
    chk(cpu_t_hold_high == 1'b0, "R8 hold_high", cpu_t_hold_high, 0);
    chk(cpu_c_oe == 1'b1, "R8 c_oe", cpu_c_oe, 1);
    chk(all_parked == 1'b0, "R8 all_parked", all_parked, 0);
    #50 rst_n = 1'b1;
    #800;
    for (int k = 0; k < ND; k++) chk(pulses[k] > 0, "R6 running after reset", pulses[k], 1);
  endtask

  task automatic t_single_low();
    @(negedge cpu_c_clk) pwrdn_n = 1'b0;
    @(negedge cpu_c_clk) pwrdn_n = 1'b1;
    repeat (3) @(negedge cpu_c_clk);
    chk(cpu_t_hold_high == 1'b0, "R1 single low sample", cpu_t_hold_high, 0);
    chk(cpu_c_oe == 1'b1, "R1 single low c_oe", cpu_c_oe, 1);
  endtask

  task automatic t_low_high_low();
    @(negedge cpu_c_clk) pwrdn_n = 1'b0;
    @(negedge cpu_c_clk) pwrdn_n = 1'b1;
    @(negedge cpu_c_clk) pwrdn_n = 1'b0;
    @(negedge cpu_c_clk) pwrdn_n = 1'b1;
    repeat (2) @(negedge cpu_c_clk);
    chk(cpu_t_hold_high == 1'b0, "R1 low-high-low", cpu_t_hold_high, 0);
    #600;
    chk(all_parked == 1'b0, "R7 stays low without accept", all_parked, 0);
  endtask

  task automatic t_park(input string tag);
    int snap [ND];
    @(negedge cpu_c_clk) pwrdn_n = 1'b0;
    @(negedge cpu_c_clk);
    chk(cpu_t_hold_high == 1'b0, {tag, " R1 not after first edge"}, cpu_t_hold_high, 0);
    @(negedge cpu_c_clk);
    chk(cpu_t_hold_high == 1'b1, {tag, " R2 hold_high on second edge"}, cpu_t_hold_high, 1);
    chk(cpu_c_oe == 1'b0, {tag, " R2 c_oe off"}, cpu_c_oe, 0);
    #600;
    for (int k = 0; k < ND; k++) snap[k] = pulses[k];
    chk(dom_out == '0, {tag, " R5 outputs parked"}, int'(dom_out), 0);
    #500;
    for (int k = 0; k < ND; k++)
      chk(pulses[k] == snap[k], {tag, " R5 stays low"}, pulses[k] - snap[k], 0);
    chk(all_parked == 1'b1, {tag, " R7 all_parked"}, all_parked, 1);
    chk(cpu_t_hold_high == 1'b1, {tag, " R2 hold kept"}, cpu_t_hold_high, 1);
  endtask

  task automatic t_release(input string tag);
    int snap [ND];
    @(negedge cpu_c_clk) pwrdn_n = 1'b1;
    for (int k = 0; k < ND; k++) snap[k] = pulses[k];
    @(negedge cpu_c_clk);
    chk(cpu_t_hold_high == 1'b0, {tag, " R3 hold released"}, cpu_t_hold_high, 0);
    chk(cpu_c_oe == 1'b1, {tag, " R3 c_oe back"}, cpu_c_oe, 1);
    #800;
    for (int k = 0; k < ND; k++)
      chk(pulses[k] > snap[k], {tag, " R6 resumes"}, pulses[k] - snap[k], 1);
    chk(all_parked == 1'b0, {tag, " R7 all_parked clears"}, all_parked, 0);
  endtask

  initial begin
    t_reset();
    t_single_low();
    t_low_high_low();
    t_park("base");
    t_release("base");
    cpu_half = 5;
    repeat (4) @(negedge cpu_c_clk);
    t_park("R9 fast");
    t_release("R9 fast");
    chk(viol == 0, "R4 every gated pulse full width", viol, 0);
    summary();
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end
endmodule